// File: doc/BRIEF.md
# DQS Group Configuration Scan Loader

This block loads the delay and phase settings of one DQS group in a source-synchronous memory interface. The settings sit in serial scan chains. It accepts parallel configuration words on a start request: one word for each DQ I/O, one for the DQS I/O and one for the DQS logic. It then drives those words onto a single shared serial data line, one bit per clock, least significant bit first. While each word is shifted, the enable of the chain that word belongs to is held high, so the chain takes exactly its own bits.

The segments follow each other with no gap. The DQ I/O segments come first, in ascending DQ order, then the DQS I/O segment, then the DQS logic segment. A single update strobe then commits the new settings, and a one-cycle done pulse returns the sequencer to idle.

The DQS logic word carries three fields that come from dedicated ports rather than from the raw word: the DQS bus-out delay code, the postamble phase invert and the postamble phase select. The unused bits directly above these fields are forced to zero. All settings are captured in the cycle that start is accepted.

Top module: `dqsl_scan_loader`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `scan_data`, `scan_update`, `scan_en_dqs_io`, `scan_en_dqs_logic` and every bit of `scan_en_dq` are low.
- R2: All configuration inputs are captured in the cycle that start is accepted. Input changes after that cycle have no effect on the serial stream.
- R3: In the cycle after start is accepted, the DQ phase begins. DQ segment i (bits `dq_cfg[i*IO_SEG_W +: IO_SEG_W]`) is shifted while `scan_en_dq` equals `1 << i`, for exactly IO_SEG_W cycles. The segments run for i = 0 up to DQ_W-1, and bit j of the segment appears in the j-th cycle of the segment.
- R4: Right after the last DQ segment, `scan_en_dqs_io` is high for exactly IO_SEG_W cycles while `dqs_io_cfg` is shifted, LSB first.
- R5: Right after the DQS I/O segment, `scan_en_dqs_logic` is high for exactly LOGIC_SEG_W cycles while the merged DQS logic word is shifted, LSB first.
- R6: In the merged DQS logic word:
  - bits 21..17 hold `busout_dly`, a code in 25 ps steps, where code 31 means 775 ps beyond the intrinsic delay;
  - bit 22 holds `pst_inv`, where 0 means no inversion;
  - bits 24..23 hold `pst_phase`, where codes 0, 1, 2 and 3 mean 0°, 45°, 90° and 135°;
  - bits 29..25 are zero;
  - every other bit comes from `dqs_logic_cfg`.
- R7: At most one of the enables is high in any cycle. The enables are the bits of `scan_en_dq`, `scan_en_dqs_io` and `scan_en_dqs_logic`. `scan_en_dq` is zero outside the DQ phase.
- R8: `scan_update` is high for exactly one cycle, right after the last DQS logic bit. In that cycle all enables and `scan_data` are low.
- R9: `done` is high for exactly one cycle, the cycle after the update. `busy` is high from the cycle after start is accepted through the done cycle, and low afterwards.
- R10: A start request while `busy` is high is ignored, and the running sequence continues unchanged.
- R11: A reset asserted in the middle of a sequence returns the block to idle with all outputs low, and a later start runs a complete sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to load all chains; accepted only when idle |
| dq_cfg | input | DQ_W*IO_SEG_W | Per-DQ I/O words, segment i at bits i*IO_SEG_W upward |
| dqs_io_cfg | input | IO_SEG_W | DQS I/O configuration word |
| dqs_logic_cfg | input | LOGIC_SEG_W | DQS logic configuration word, raw |
| busout_dly | input | 5 | DQS bus-out delay code, 25 ps per step |
| pst_inv | input | 1 | Postamble phase invert |
| pst_phase | input | 2 | Postamble phase select, 45° per step |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| scan_data | output | 1 | Shared serial configuration data |
| scan_en_dq | output | DQ_W | One-hot per-DQ chain enables |
| scan_en_dqs_io | output | 1 | DQS I/O chain enable |
| scan_en_dqs_logic | output | 1 | DQS logic chain enable |
| scan_update | output | 1 | One-cycle update strobe |

## Verification
The bench builds the block with its default parameters: eight DQ chains, 40-bit I/O segments and a 101-bit logic segment. With these values every one-hot step of the DQ enable bus occurs, including the final step to bit 7. The logic word is also wide enough to hold the whole field overlay, including the forced-zero bits 29..25. The bench compares every cycle of full sequences against a model built from the requirements. The sequences cover random words, all-ones words with maximum field codes, a start held high with inputs changing mid-run, and a reset in the middle of the DQ phase.

// File: rtl/dqsl_pkg.sv
package dqsl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DQ        = 3'd1,
        ST_DQS_IO    = 3'd2,
        ST_DQS_LOGIC = 3'd3,
        ST_UPDATE    = 3'd4,
        ST_DONE      = 3'd5
    } seq_state_e;

    // Field positions inside the DQS logic word; the chain decodes them.
    localparam int DLY_LSB   = 17;
    localparam int DLY_W     = 5;
    localparam int INV_BIT   = 22;
    localparam int PH_LSB    = 23;
    localparam int PH_W      = 2;
    localparam int SPARE_LSB = 25;
    localparam int SPARE_W   = 5;
    localparam int FIELD_TOP = SPARE_LSB + SPARE_W;

    typedef struct packed {
        logic [DLY_W-1:0] dly;
        logic             inv;
        logic [PH_W-1:0]  phase;
    } dqs_field_t;

    typedef struct packed {
        logic en_io;
        logic en_logic;
        logic update;
        logic done;
        logic busy;
    } scan_ctl_t;

    function automatic logic is_shifting(seq_state_e s);
        return (s == ST_DQ) || (s == ST_DQS_IO) || (s == ST_DQS_LOGIC);
    endfunction

endpackage

// File: rtl/dqsl_field_merge.sv
module dqsl_field_merge
    import dqsl_pkg::*;
#(
    parameter int LOGIC_SEG_W = 101
) (
    input  logic [LOGIC_SEG_W-1:0] raw_word,
    input  dqs_field_t             fields,
    output logic [LOGIC_SEG_W-1:0] merged_word
);

    generate
        if (LOGIC_SEG_W >= FIELD_TOP) begin : g_overlay
            always_comb begin
                merged_word                       = raw_word;
                merged_word[DLY_LSB +: DLY_W]     = fields.dly;
                merged_word[INV_BIT]              = fields.inv;
                merged_word[PH_LSB +: PH_W]       = fields.phase;
                merged_word[SPARE_LSB +: SPARE_W] = '0;
            end
        end else begin : g_pass
            assign merged_word = raw_word;
        end
    endgenerate

endmodule

// File: rtl/dqsl_seq_ctrl.sv
module dqsl_seq_ctrl
    import dqsl_pkg::*;
#(
    parameter int DQ_W        = 8,
    parameter int IO_SEG_W    = 40,
    parameter int LOGIC_SEG_W = 101,
    localparam int IDX_W      = (DQ_W > 1) ? $clog2(DQ_W) : 1,
    localparam int MAX_SEG    = (IO_SEG_W > LOGIC_SEG_W) ? IO_SEG_W : LOGIC_SEG_W,
    localparam int CNT_W      = $clog2(MAX_SEG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output seq_state_e       state,
    output logic [IDX_W-1:0] dq_idx,
    output logic             accept
);

    logic [CNT_W-1:0] bit_cnt;
    logic             io_last;
    logic             logic_last;
    logic             dq_last;

    assign accept     = (state == ST_IDLE) && start;
    assign io_last    = (bit_cnt == CNT_W'(IO_SEG_W - 1));
    assign logic_last = (bit_cnt == CNT_W'(LOGIC_SEG_W - 1));
    assign dq_last    = (dq_idx == IDX_W'(DQ_W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            dq_idx  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    bit_cnt <= '0;
                    dq_idx  <= '0;
                    if (start) state <= ST_DQ;
                end
                ST_DQ: begin
                    if (io_last) begin
                        bit_cnt <= '0;
                        if (dq_last) begin
                            dq_idx <= '0;
                            state  <= ST_DQS_IO;
                        end else begin
                            dq_idx <= dq_idx + 1'b1;
                        end
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_DQS_IO: begin
                    if (io_last) begin
                        bit_cnt <= '0;
                        state   <= ST_DQS_LOGIC;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_DQS_LOGIC: begin
                    if (logic_last) begin
                        bit_cnt <= '0;
                        state   <= ST_UPDATE;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_UPDATE: state <= ST_DONE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        dq_idx <= IDX_W'(DQ_W - 1)); // R3

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (is_shifting(state) || state == ST_UPDATE) |=> (state != ST_IDLE)); // R10

    AST_UPDATE_AFTER_LOGIC: assert property (@(posedge clk) disable iff (rst)
        (state == ST_UPDATE) |-> ($past(state) == ST_DQS_LOGIC)); // R8

endmodule

// File: rtl/dqsl_shift_bank.sv
module dqsl_shift_bank
    import dqsl_pkg::*;
#(
    parameter int DQ_W        = 8,
    parameter int IO_SEG_W    = 40,
    parameter int LOGIC_SEG_W = 101,
    localparam int DQ_BITS    = DQ_W * IO_SEG_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  seq_state_e             state,
    input  logic [DQ_BITS-1:0]     dq_word,
    input  logic [IO_SEG_W-1:0]    io_word,
    input  logic [LOGIC_SEG_W-1:0] logic_word,
    output logic                   ser_bit
);

    logic [DQ_BITS-1:0]     dq_sr;
    logic [IO_SEG_W-1:0]    io_sr;
    logic [LOGIC_SEG_W-1:0] lg_sr;

    // DQ segments are concatenated, so one right shift walks segment 0 LSB
    // first and then continues straight into segment 1 and upward.
    always_ff @(posedge clk) begin
        if (rst) begin
            dq_sr <= '0;
            io_sr <= '0;
            lg_sr <= '0;
        end else if (load) begin
            dq_sr <= dq_word;
            io_sr <= io_word;
            lg_sr <= logic_word;
        end else begin
            if (state == ST_DQ)        dq_sr <= dq_sr >> 1;
            if (state == ST_DQS_IO)    io_sr <= io_sr >> 1;
            if (state == ST_DQS_LOGIC) lg_sr <= lg_sr >> 1;
        end
    end

    always_comb begin
        case (state)
            ST_DQ:        ser_bit = dq_sr[0];
            ST_DQS_IO:    ser_bit = io_sr[0];
            ST_DQS_LOGIC: ser_bit = lg_sr[0];
            default:      ser_bit = 1'b0;
        endcase
    end

    AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        load |-> (state == ST_IDLE)); // R2

endmodule

// File: rtl/dqsl_enable_decode.sv
module dqsl_enable_decode
    import dqsl_pkg::*;
#(
    parameter int DQ_W   = 8,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_state_e       state,
    input  logic [IDX_W-1:0] dq_idx,
    input  logic             ser_bit,
    output logic [DQ_W-1:0]  en_dq,
    output scan_ctl_t        ctl
);

    genvar g;
    generate
        for (g = 0; g < DQ_W; g++) begin : g_dq_en
            assign en_dq[g] = (state == ST_DQ) && (dq_idx == IDX_W'(g));
        end
    endgenerate

    always_comb begin
        ctl.en_io    = (state == ST_DQS_IO);
        ctl.en_logic = (state == ST_DQS_LOGIC);
        ctl.update   = (state == ST_UPDATE);
        ctl.done     = (state == ST_DONE);
        ctl.busy     = (state != ST_IDLE);
    end

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        ($countones({en_dq, ctl.en_io, ctl.en_logic}) <= 1)); // R7

    AST_UPDATE_QUIET: assert property (@(posedge clk) disable iff (rst)
        ctl.update |-> (en_dq == '0 && !ctl.en_io && !ctl.en_logic && !ser_bit)); // R8

    AST_UPDATE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctl.update |=> !ctl.update); // R8

    AST_DONE_FOLLOWS_UPDATE: assert property (@(posedge clk) disable iff (rst)
        ctl.update |=> (ctl.done && ctl.busy)); // R9

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        ctl.done |=> (!ctl.busy && !ctl.done)); // R9

endmodule

// File: rtl/dqsl_scan_loader.sv
module dqsl_scan_loader
    import dqsl_pkg::*;
#(
    parameter int DQ_W        = 8,
    parameter int IO_SEG_W    = 40,
    parameter int LOGIC_SEG_W = 101,
    localparam int IDX_W      = (DQ_W > 1) ? $clog2(DQ_W) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [DQ_W*IO_SEG_W-1:0]  dq_cfg,
    input  logic [IO_SEG_W-1:0]       dqs_io_cfg,
    input  logic [LOGIC_SEG_W-1:0]    dqs_logic_cfg,
    input  logic [4:0]                busout_dly,
    input  logic                      pst_inv,
    input  logic [1:0]                pst_phase,
    output logic                      busy,
    output logic                      done,
    output logic                      scan_data,
    output logic [DQ_W-1:0]           scan_en_dq,
    output logic                      scan_en_dqs_io,
    output logic                      scan_en_dqs_logic,
    output logic                      scan_update
);

    seq_state_e             state;
    logic [IDX_W-1:0]       dq_idx;
    logic                   accept;
    logic [LOGIC_SEG_W-1:0] merged_logic;
    logic                   ser_bit;
    dqs_field_t             fields;
    scan_ctl_t              ctl;

    assign fields = '{dly: busout_dly, inv: pst_inv, phase: pst_phase};

    dqsl_seq_ctrl #(
        .DQ_W        (DQ_W),
        .IO_SEG_W    (IO_SEG_W),
        .LOGIC_SEG_W (LOGIC_SEG_W)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .state  (state),
        .dq_idx (dq_idx),
        .accept (accept)
    );

    dqsl_field_merge #(
        .LOGIC_SEG_W (LOGIC_SEG_W)
    ) u_merge (
        .raw_word    (dqs_logic_cfg),
        .fields      (fields),
        .merged_word (merged_logic)
    );

    dqsl_shift_bank #(
        .DQ_W        (DQ_W),
        .IO_SEG_W    (IO_SEG_W),
        .LOGIC_SEG_W (LOGIC_SEG_W)
    ) u_bank (
        .clk        (clk),
        .rst        (rst),
        .load       (accept),
        .state      (state),
        .dq_word    (dq_cfg),
        .io_word    (dqs_io_cfg),
        .logic_word (merged_logic),
        .ser_bit    (ser_bit)
    );

    dqsl_enable_decode #(
        .DQ_W  (DQ_W),
        .IDX_W (IDX_W)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .dq_idx  (dq_idx),
        .ser_bit (ser_bit),
        .en_dq   (scan_en_dq),
        .ctl     (ctl)
    );

    assign scan_data         = ser_bit;
    assign scan_en_dqs_io    = ctl.en_io;
    assign scan_en_dqs_logic = ctl.en_logic;
    assign scan_update       = ctl.update;
    assign done              = ctl.done;
    assign busy              = ctl.busy;

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && scan_en_dq[0])); // R3

    AST_DQ_NOT_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (scan_en_dqs_io || scan_en_dqs_logic || scan_update || !busy) |-> (scan_en_dq == '0)); // R7

endmodule

// File: tb/dqsl_scan_loader_tb.sv
module dqsl_scan_loader_tb_top;

    localparam int CLK_PERIOD  = 10;
    localparam int DQ_W        = 8;
    localparam int IO_SEG_W    = 40;
    localparam int LOGIC_SEG_W = 101;
    localparam int DQ_BITS     = DQ_W * IO_SEG_W;
    localparam int TOTAL       = DQ_BITS + IO_SEG_W + LOGIC_SEG_W;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   start;
    logic [DQ_BITS-1:0]     dq_cfg;
    logic [IO_SEG_W-1:0]    dqs_io_cfg;
    logic [LOGIC_SEG_W-1:0] dqs_logic_cfg;
    logic [4:0]             busout_dly;
    logic                   pst_inv;
    logic [1:0]             pst_phase;
    logic                   busy, done, scan_data, scan_en_dqs_io, scan_en_dqs_logic, scan_update;
    logic [DQ_W-1:0]        scan_en_dq;

    int n_checks = 0;
    int n_fail   = 0;

    // expected words, frozen at start
    logic [DQ_BITS-1:0]     x_dq;
    logic [IO_SEG_W-1:0]    x_io;
    logic [LOGIC_SEG_W-1:0] x_lg;

    always #(CLK_PERIOD/2) clk = ~clk;

    dqsl_scan_loader #(
        .DQ_W        (DQ_W),
        .IO_SEG_W    (IO_SEG_W),
        .LOGIC_SEG_W (LOGIC_SEG_W)
    ) dut_i (
        .clk               (clk),
        .rst               (rst),
        .start             (start),
        .dq_cfg            (dq_cfg),
        .dqs_io_cfg        (dqs_io_cfg),
        .dqs_logic_cfg     (dqs_logic_cfg),
        .busout_dly        (busout_dly),
        .pst_inv           (pst_inv),
        .pst_phase         (pst_phase),
        .busy              (busy),
        .done              (done),
        .scan_data         (scan_data),
        .scan_en_dq        (scan_en_dq),
        .scan_en_dqs_io    (scan_en_dqs_io),
        .scan_en_dqs_logic (scan_en_dqs_logic),
        .scan_update       (scan_update)
    );

    // Output bundle: {busy, done, data, en_dq, en_io, en_logic, update}
    function automatic logic [DQ_W+5:0] pack_out();
        return {busy, done, scan_data, scan_en_dq, scan_en_dqs_io, scan_en_dqs_logic, scan_update};
    endfunction

    task automatic check(input string req, input logic [DQ_W+5:0] exp_v, input int cyc);
        n_checks++;
        if (pack_out() !== exp_v) begin
            n_fail++;
            $display("FAIL %s cycle %0d: outputs actual %b expected %b", req, cyc, pack_out(), exp_v);
        end
    endtask

    // R6: expected merged logic word from requirement field positions
    function automatic logic [LOGIC_SEG_W-1:0] merge_model(input logic [LOGIC_SEG_W-1:0] w,
                                                           input logic [4:0] d, input logic inv,
                                                           input logic [1:0] ph);
        logic [LOGIC_SEG_W-1:0] r = w;
        for (int b = 17; b <= 21; b++) r[b] = d[b-17];
        r[22] = inv;
        r[23] = ph[0];
        r[24] = ph[1];
        for (int b = 25; b <= 29; b++) r[b] = 1'b0;
        return r;
    endfunction

    function automatic logic [DQ_W+5:0] expect_at(input int c);
        logic [DQ_W-1:0] en = '0;
        if (c < DQ_BITS) begin
            en[c / IO_SEG_W] = 1'b1;
            return {1'b1, 1'b0, x_dq[c], en, 1'b0, 1'b0, 1'b0};
        end else if (c < DQ_BITS + IO_SEG_W)
            return {1'b1, 1'b0, x_io[c-DQ_BITS], en, 1'b1, 1'b0, 1'b0};
        else if (c < TOTAL)
            return {1'b1, 1'b0, x_lg[c-DQ_BITS-IO_SEG_W], en, 1'b0, 1'b1, 1'b0};
        else if (c == TOTAL)
            return {1'b1, 1'b0, 1'b0, en, 1'b0, 1'b0, 1'b1};
        else if (c == TOTAL + 1)
            return {1'b1, 1'b1, 1'b0, en, 1'b0, 1'b0, 1'b0};
        return '0;
    endfunction

    function automatic string req_at(input int c);
        if (c < DQ_BITS) return "R3";
        if (c < DQ_BITS + IO_SEG_W) return "R4";
        if (c < TOTAL) return "R5/R6";
        if (c == TOTAL) return "R8";
        return "R9";
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1", '0, -1);
    endtask

    // Runs one sequence. hold_start keeps start high throughout (R10);
    // scramble changes every input after acceptance (R2).
    task automatic run_seq(input logic hold_start, input logic scramble, input string tag);
        x_dq = dq_cfg;
        x_io = dqs_io_cfg;
        x_lg = merge_model(dqs_logic_cfg, busout_dly, pst_inv, pst_phase);
        start = 1'b1;
        @(negedge clk);
        if (!hold_start) start = 1'b0;
        for (int c = 0; c <= TOTAL + 2; c++) begin
            check(req_at(c), expect_at(c), c);
            if (scramble) begin
                dq_cfg        = ~dq_cfg;
                dqs_io_cfg    = ~dqs_io_cfg;
                dqs_logic_cfg = ~dqs_logic_cfg;
                busout_dly    = busout_dly + 5'd3;
                pst_inv       = ~pst_inv;
                pst_phase     = pst_phase + 2'd1;
            end
            if (c == TOTAL) start = 1'b0;
            @(negedge clk);
        end
        check({"R9 idle after ", tag}, '0, TOTAL + 3);
    endtask

    task automatic fill_random();
        for (int i = 0; i < DQ_BITS; i++) dq_cfg[i] = 1'($urandom);
        for (int i = 0; i < IO_SEG_W; i++) dqs_io_cfg[i] = 1'($urandom);
        for (int i = 0; i < LOGIC_SEG_W; i++) dqs_logic_cfg[i] = 1'($urandom);
        busout_dly = 5'($urandom);
        pst_inv    = 1'($urandom);
        pst_phase  = 2'($urandom);
    endtask

    task automatic test_random();
        fill_random();
        run_seq(1'b0, 1'b0, "random");
    endtask

    task automatic test_all_ones();
        dq_cfg        = '1;
        dqs_io_cfg    = '1;
        dqs_logic_cfg = '1;
        busout_dly    = 5'd31;  // R6: 775 ps code
        pst_inv       = 1'b1;
        pst_phase     = 2'd3;   // R6: 135 degrees
        run_seq(1'b0, 1'b0, "ones");
    endtask

    task automatic test_zero_fields();
        fill_random();
        busout_dly = 5'd0;
        pst_inv    = 1'b0;
        pst_phase  = 2'd2;      // R6: 90 degrees
        run_seq(1'b0, 1'b0, "fields");
    endtask

    task automatic test_busy_start_and_late_change();
        fill_random();
        run_seq(1'b1, 1'b1, "held");   // R2, R10
    endtask

    task automatic test_mid_reset();
        fill_random();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 100; c++) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R11", '0, -1);
        @(negedge clk);
        check("R11", '0, -1);
        fill_random();
        run_seq(1'b0, 1'b0, "after reset");  // R11
    endtask

    initial begin
        rst = 1'b1; start = 1'b0;
        dq_cfg = '0; dqs_io_cfg = '0; dqs_logic_cfg = '0;
        busout_dly = '0; pst_inv = 1'b0; pst_phase = '0;
        do_reset();
        test_random();
        test_all_ones();
        test_zero_fields();
        test_busy_start_and_late_change();
        test_mid_reset();
        test_random();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule